// File: doc/BRIEF.md
# Slave Address Match and Wakeup Unit

This block sits beside a serial bus receiver. It holds a slave address that the CPU programs and compares it with each byte the receiver marks as an address. A coincidence flag shows whether this device was selected. A release flag is cleared when the address did not match and is set again when the bus stops. The same comparator also checks a byte this device sent as master and raises an error flag when the byte on the bus differs from the stored address.

An interrupt request is produced as a single-cycle pulse. In normal operation every completed byte requests an interrupt. When wakeup is enabled in a bus mode, only a matching address or a stop condition does, so the CPU can sleep until the master addresses it. A mask option compares only the upper seven address bits. In the plain three-wire mode the comparator takes no part.

All outputs are registered and change one clock after the strobe that causes them. Reset is synchronous and active high.

Top module: `slave_addr_wake`

## Requirements
- R1: A write on `sa_we` stores `sa_wdata` as the slave address, and it is used from the next cycle on. Reset does not alter the stored address.
- R2: In a bus mode (`mode_sel` not 2'b00), an `addr_stb` sets `match_o` one cycle later: to 1 when `rx_byte` equals the slave address in all 8 bits, otherwise to 0.
- R3: With `mask_lsb`=1, bit 0 is left out of every compare, so addresses that differ only in bit 0 match.
- R4: In a bus mode, an `addr_stb` whose compare fails clears `release_o` one cycle later. `stop_stb` sets `release_o` one cycle later and wins over a mismatch in the same cycle.
- R5: While wakeup is active (`wake_en`=1 and a bus mode), `irq_o` pulses one cycle after a matching `addr_stb` or after `stop_stb`. A failing address or a `byte_done` raises no request.
- R6: While wakeup is inactive (`wake_en`=0, or mode 2'b00), `irq_o` pulses one cycle after every `byte_done`, whatever the compare result. `addr_stb` and `stop_stb` alone raise no request.
- R7: `irq_o` is high for one cycle per strobe cycle. A matching address together with a stop in the same cycle gives one single-cycle pulse.
- R8: `clr_match` clears `match_o` and `err_o` one cycle later. An `addr_stb` in the same cycle decides `match_o`, and a `tx_chk_stb` in the same cycle decides `err_o`.
- R9: In a bus mode, a `tx_chk_stb` sets `err_o` one cycle later to 1 when `rx_byte` fails the compare (mask as in R3), and to 0 when it passes.
- R10: In mode 2'b00, `addr_stb` and `tx_chk_stb` have no effect on `match_o`, `release_o` or `err_o`.
- R11: While `rst` is high at a clock edge, `match_o`, `irq_o`, `release_o` and `err_o` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sa_we | input | 1 | Slave address write strobe |
| sa_wdata | input | ADDR_W (8) | Slave address write data |
| mask_lsb | input | 1 | Leave bit 0 out of the compare |
| wake_en | input | 1 | Wakeup gating of interrupts |
| mode_sel | input | 2 | 00 three-wire, 01/10/11 bus modes |
| rx_byte | input | ADDR_W (8) | Byte taken from the bus |
| addr_stb | input | 1 | rx_byte holds a received address |
| byte_done | input | 1 | A byte transfer finished |
| stop_stb | input | 1 | Stop condition detected |
| tx_chk_stb | input | 1 | rx_byte holds a byte sent as master |
| clr_match | input | 1 | CPU clear of match and error flags |
| match_o | output | 1 | Address coincidence flag |
| irq_o | output | 1 | Interrupt request pulse |
| release_o | output | 1 | Bus release detect flag |
| err_o | output | 1 | Transmit compare error flag |

## Verification
A wrong stored address or mask would show one cycle after the next address strobe, as a wrong `match_o` and a `release_o` that drops when it should not. A gating fault shows in the cycle after a strobe as a missing or extra `irq_o` pulse. The bench runs a behavioural model alongside the design and compares all four outputs on every clock. Any divergence is therefore reported in the first cycle it appears at the ports. Reset retention of the address is visible at the first address strobe after reset.

// File: rtl/saw_pkg.sv
package saw_pkg;
  typedef enum logic [1:0] {
    MODE_3WIRE = 2'b00,
    MODE_2WIRE = 2'b01,
    MODE_SBUS  = 2'b10,
    MODE_XBUS  = 2'b11
  } saw_mode_e;

  typedef struct packed {
    logic addr;
    logic done;
    logic stop;
    logic chk;
    logic clr;
  } saw_evt_t;

  function automatic logic is_bus_mode(input saw_mode_e m);
    return m != MODE_3WIRE;
  endfunction
endpackage

// File: rtl/saw_addr_cmp.sv
module saw_addr_cmp #(
  parameter int ADDR_W    = 8,
  parameter int MASK_LSBS = 1
) (
  input  logic              clk,
  input  logic              sa_we,
  input  logic [ADDR_W-1:0] sa_wdata,
  input  logic              mask_en,
  input  logic [ADDR_W-1:0] rx_byte,
  output logic              hit
);
  localparam int KEEP_W = ADDR_W - MASK_LSBS;

  logic [ADDR_W-1:0] sva_q;
  logic [ADDR_W-1:0] cmp_mask;

  // Address register deliberately has no reset: its value survives reset.
  always_ff @(posedge clk) begin
    if (sa_we) sva_q <= sa_wdata;
  end

  generate
    if (MASK_LSBS > 0) begin : g_mask
      assign cmp_mask = mask_en ? {{KEEP_W{1'b1}}, {MASK_LSBS{1'b0}}} : {ADDR_W{1'b1}};
    end else begin : g_nomask
      assign cmp_mask = {ADDR_W{1'b1}};
    end
  endgenerate

  assign hit = ((rx_byte ^ sva_q) & cmp_mask) == '0;
endmodule

// File: rtl/saw_flags.sv
module saw_flags
  import saw_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     bus,
  input  logic     hit,
  input  saw_evt_t evt,
  output logic     match_q,
  output logic     rel_q,
  output logic     err_q
);
  logic addr_ev, chk_ev;
  assign addr_ev = bus & evt.addr;
  assign chk_ev  = bus & evt.chk;

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= 1'b0;
      rel_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (addr_ev)       match_q <= hit;
      else if (evt.clr)  match_q <= 1'b0;

      if (evt.stop)              rel_q <= 1'b1;
      else if (addr_ev && !hit)  rel_q <= 1'b0;

      if (chk_ev)        err_q <= !hit;
      else if (evt.clr)  err_q <= 1'b0;
    end
  end

  p_match_r2: assert property (@(posedge clk) disable iff (rst)
    (bus && evt.addr) |=> (match_q == $past(hit)));

  p_mismatch_release_r4: assert property (@(posedge clk) disable iff (rst)
    (bus && evt.addr && !hit && !evt.stop) |=> !rel_q);

  p_stop_release_r4: assert property (@(posedge clk) disable iff (rst)
    evt.stop |=> rel_q);

  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (evt.clr && !(bus && evt.addr)) |=> !match_q);

  p_tx_error_r9: assert property (@(posedge clk) disable iff (rst)
    (bus && evt.chk) |=> (err_q != $past(hit)));

  p_three_wire_r10: assert property (@(posedge clk) disable iff (rst)
    (!bus && !evt.clr && !evt.stop) |=> ($stable(match_q) && $stable(err_q) && $stable(rel_q)));
endmodule

// File: rtl/saw_irq.sv
module saw_irq
  import saw_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     wake,
  input  logic     bus,
  input  logic     hit,
  input  saw_evt_t evt,
  output logic     irq_q
);
  logic gated, irq_d;
  assign gated = wake & bus;
  assign irq_d = gated ? ((evt.addr & hit) | evt.stop) : evt.done;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= irq_d;
  end

  p_wake_gate_r5: assert property (@(posedge clk) disable iff (rst)
    (wake && bus && !evt.stop && !(evt.addr && hit)) |=> !irq_q);

  p_wake_fire_r5: assert property (@(posedge clk) disable iff (rst)
    (wake && bus && evt.stop) |=> irq_q);

  p_nowake_byte_r6: assert property (@(posedge clk) disable iff (rst)
    (!(wake && bus) && evt.done) |=> irq_q);

  p_pulse_source_r7: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(evt.done || evt.stop || evt.addr));
endmodule

// File: rtl/slave_addr_wake.sv
module slave_addr_wake
  import saw_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int MASK_LSBS = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sa_we,
  input  logic [ADDR_W-1:0] sa_wdata,
  input  logic              mask_lsb,
  input  logic              wake_en,
  input  logic [1:0]        mode_sel,
  input  logic [ADDR_W-1:0] rx_byte,
  input  logic              addr_stb,
  input  logic              byte_done,
  input  logic              stop_stb,
  input  logic              tx_chk_stb,
  input  logic              clr_match,
  output logic              match_o,
  output logic              irq_o,
  output logic              release_o,
  output logic              err_o
);
  saw_evt_t  evt;
  saw_mode_e mode;
  logic      bus, hit;

  assign mode = saw_mode_e'(mode_sel);
  assign bus  = is_bus_mode(mode);
  assign evt  = '{addr: addr_stb, done: byte_done, stop: stop_stb,
                  chk: tx_chk_stb, clr: clr_match};

  saw_addr_cmp #(.ADDR_W(ADDR_W), .MASK_LSBS(MASK_LSBS)) u_cmp (
    .clk      (clk),
    .sa_we    (sa_we),
    .sa_wdata (sa_wdata),
    .mask_en  (mask_lsb),
    .rx_byte  (rx_byte),
    .hit      (hit)
  );

  saw_flags u_flags (
    .clk     (clk),
    .rst     (rst),
    .bus     (bus),
    .hit     (hit),
    .evt     (evt),
    .match_q (match_o),
    .rel_q   (release_o),
    .err_q   (err_o)
  );

  saw_irq u_irq (
    .clk   (clk),
    .rst   (rst),
    .wake  (wake_en),
    .bus   (bus),
    .hit   (hit),
    .evt   (evt),
    .irq_q (irq_o)
  );

  p_reset_r11: assert property (@(posedge clk)
    rst |=> (!match_o && !irq_o && !release_o && !err_o));
endmodule

// File: tb/slave_addr_wake_test.sv
`timescale 1ns/1ps
module slave_addr_wake_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sa_we = 0, mask_lsb = 0, wake_en = 0;
  logic [7:0] sa_wdata = 0, rx_byte = 0;
  logic [1:0] mode_sel = 0;
  logic       addr_stb = 0, byte_done = 0, stop_stb = 0, tx_chk_stb = 0, clr_match = 0;
  logic       match_o, irq_o, release_o, err_o;

  int    tests = 0, fails = 0, cycles = 0;
  bit    started = 0;
  string tag = "R11";

  // behavioural reference state
  int       e_match = 0, e_irq = 0, e_rel = 0, e_err = 0;
  bit [7:0] e_addr = 0;

  always #4 clk = ~clk;

  slave_addr_wake uut (
    .clk(clk), .rst(rst), .sa_we(sa_we), .sa_wdata(sa_wdata), .mask_lsb(mask_lsb),
    .wake_en(wake_en), .mode_sel(mode_sel), .rx_byte(rx_byte), .addr_stb(addr_stb),
    .byte_done(byte_done), .stop_stb(stop_stb), .tx_chk_stb(tx_chk_stb),
    .clr_match(clr_match), .match_o(match_o), .irq_o(irq_o), .release_o(release_o),
    .err_o(err_o)
  );

  always @(posedge clk) begin
    bit onbus, same;
    cycles++;
    started = 1;
    if (rst) begin
      e_match = 0; e_irq = 0; e_rel = 0; e_err = 0;
    end else begin
      onbus = (mode_sel != 2'b00);
      same  = mask_lsb ? (rx_byte[7:1] == e_addr[7:1]) : (rx_byte == e_addr);
      if (wake_en && onbus) e_irq = ((addr_stb && same) || stop_stb) ? 1 : 0;
      else                  e_irq = byte_done ? 1 : 0;
      if (onbus && addr_stb) e_match = same ? 1 : 0;
      else if (clr_match)    e_match = 0;
      if (stop_stb)                        e_rel = 1;
      else if (onbus && addr_stb && !same) e_rel = 0;
      if (onbus && tx_chk_stb) e_err = same ? 0 : 1;
      else if (clr_match)      e_err = 0;
    end
    if (sa_we) e_addr = sa_wdata;
  end

  task automatic cmp(string name, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual %0d expected %0d at cycle %0d", tag, name, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      cmp("match_o", int'(match_o), e_match);
      cmp("irq_o", int'(irq_o), e_irq);
      cmp("release_o", int'(release_o), e_rel);
      cmp("err_o", int'(err_o), e_err);
    end
  end

  task automatic idle();
    sa_we = 0; addr_stb = 0; byte_done = 0; stop_stb = 0; tx_chk_stb = 0; clr_match = 0;
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
    idle();
  endtask

  task automatic send_addr(input logic [7:0] b);
    rx_byte = b; addr_stb = 1; byte_done = 1; step();
  endtask

  initial begin
    repeat (2) @(negedge clk);
    tag = "R11"; rst = 0; step(2);
    tag = "R1";  sa_we = 1; sa_wdata = 8'h5A; step(); mode_sel = 2'b01;
    send_addr(8'h5A); step();
    tag = "R4";  stop_stb = 1; step(); step();
    tag = "R2";  send_addr(8'h5B); step(); send_addr(8'hA5); step();
    tag = "R3";  mask_lsb = 1; send_addr(8'h5B); step(); send_addr(8'h58); step(); mask_lsb = 0;
    tag = "R4";  stop_stb = 1; step(); rx_byte = 8'h00; addr_stb = 1; stop_stb = 1; step(); step();
    tag = "R5";  wake_en = 1; mode_sel = 2'b10;
    byte_done = 1; step(); step(); send_addr(8'h11); step();
    send_addr(8'h5A); step(); stop_stb = 1; step(); step();
    tag = "R7";  rx_byte = 8'h5A; addr_stb = 1; stop_stb = 1; step(); step(2);
    tag = "R6";  wake_en = 0; send_addr(8'h11); step(); stop_stb = 1; step();
    addr_stb = 1; rx_byte = 8'h5A; step();
    wake_en = 1; mode_sel = 2'b00; byte_done = 1; step(); step(); wake_en = 0; mode_sel = 2'b01;
    tag = "R9";  rx_byte = 8'h5B; tx_chk_stb = 1; step(); step();
    rx_byte = 8'h5A; tx_chk_stb = 1; step(); rx_byte = 8'h5B; tx_chk_stb = 1; step();
    tag = "R8";  send_addr(8'h5A); clr_match = 1; step(); step();
    send_addr(8'h5A); clr_match = 1; rx_byte = 8'h5A; addr_stb = 1; step();
    rx_byte = 8'h00; tx_chk_stb = 1; clr_match = 1; step(); clr_match = 1; step();
    tag = "R10"; mode_sel = 2'b00; rx_byte = 8'h00; addr_stb = 1; step();
    tx_chk_stb = 1; step(); rx_byte = 8'h5A; addr_stb = 1; step(); step();
    mode_sel = 2'b01;
    tag = "R11"; send_addr(8'h5A); stop_stb = 1; step(); rst = 1; step(2); rst = 0; step();
    tag = "R1";  send_addr(8'h5A); step();
    sa_we = 1; sa_wdata = 8'h3C; rx_byte = 8'h3C; addr_stb = 1; step(); send_addr(8'h3C); step();
    tag = "RND";
    for (int i = 0; i < 600; i++) begin
      sa_we      = ($urandom_range(0, 15) == 0);
      sa_wdata   = 8'h3C ^ 8'($urandom_range(0, 3));
      rx_byte    = 8'h3C ^ 8'($urandom_range(0, 3));
      mask_lsb   = 1'($urandom_range(0, 1));
      wake_en    = 1'($urandom_range(0, 1));
      mode_sel   = 2'($urandom_range(0, 3));
      addr_stb   = 1'($urandom_range(0, 1));
      byte_done  = 1'($urandom_range(0, 1));
      stop_stb   = ($urandom_range(0, 5) == 0);
      tx_chk_stb = ($urandom_range(0, 3) == 0);
      clr_match  = ($urandom_range(0, 5) == 0);
      @(negedge clk);
    end
    idle(); step(2);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired at cycle %0d", cycles);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule